// File: doc/BRIEF.md
# Branch Condition Code Evaluator

This block judges whether a conditional branch or a set-on-condition instruction holds. Each request carries a 4-bit condition selector, the current status flags (negative, zero, overflow, carry and a separate P flag), two context bits, and the result of the most recent operation. The block returns a registered taken bit, plus the register value a set-on-condition instruction writes: exactly one when the condition holds, zero otherwise.

The evaluator has a fast path. When the flags have not been brought up to date (not live) and the last operation was arithmetic, the equal and not-equal conditions are decided by testing the stored result for zero, not by reading the zero flag. Every other condition always reads the flags. Any non-zero intermediate test counts as true.

The output stage is a two-state machine. ST_EMPTY means no result is presented. ST_HOLD means a result is presented on the outputs. The transition EMPTY->HOLD and the transition HOLD->HOLD are both taken on a cycle with in_valid high. The transition HOLD->EMPTY and the self-loop EMPTY->EMPTY are taken on a cycle with in_valid low. Reset forces ST_EMPTY.

Top module: `branch_cond_eval`

## Requirements
- R1: in_flags bit positions are C=bit0, V=bit1, Z=bit2, N=bit3, P=bit4. Condition codes are CC=0 (C clear), CS=1 (C set), NE=2, EQ=3, VC=4 (V clear), VS=5 (V set). On the flag path, EQ is true when Z=1 and NE is true when Z=0.
- R2: PL=6 is true when N=0, and MI=7 is true when N=1.
- R3: LS=8 is true when C or Z is set, and HI=9 is true when both C and Z are clear.
- R4: GE=10 is true when N equals V, and LT=11 is true when N differs from V.
- R5: GT=12 is true when Z=0 and N equals V. LE=13 is true when Z=1 or N differs from V.
- R6: A=14 is true whatever the flags are, and P=15 is true when the P flag is set.
- R7: When in_flags_live=0 and in_last_arith=1, EQ is true exactly when in_result is zero, NE is true exactly when in_result is non-zero, and the Z flag has no effect on either.
- R8: The fast path applies to EQ and NE only. Every other condition reads the flags even when the fast-path context is present. EQ and NE read Z whenever in_flags_live=1 or in_last_arith=0.
- R9: out_set_value is 1 when out_taken is 1 and 0 otherwise, and all its upper bits are zero.
- R10: out_valid rises exactly one cycle after a cycle with in_valid high, and is low in a cycle after one with in_valid low. Reset clears out_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_cond | input | 4 | Condition selector |
| in_flags | input | 5 | Status flags {P,N,Z,V,C} |
| in_flags_live | input | 1 | Flags are up to date |
| in_last_arith | input | 1 | Last operation was arithmetic |
| in_result | input | DATA_W | Result of the last operation |
| out_valid | output | 1 | Result presented |
| out_taken | output | 1 | Condition holds |
| out_set_value | output | DATA_W | Value for set-on-condition (0 or 1) |

## Verification
The assertions assume that in_cond, in_flags and the context bits are driven to known values in every cycle where in_valid is high. They also assume that no request is made while reset is active. The stimulus drives every input on the falling edge and keeps reset low for only the first cycles, before any request. The sweep covers every condition code against every flag combination under all four settings of the context bits, with zero and non-zero results that place a single bit at both ends of the word.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    typedef enum logic [3:0] {
        COND_CC = 4'd0,
        COND_CS = 4'd1,
        COND_NE = 4'd2,
        COND_EQ = 4'd3,
        COND_VC = 4'd4,
        COND_VS = 4'd5,
        COND_PL = 4'd6,
        COND_MI = 4'd7,
        COND_LS = 4'd8,
        COND_HI = 4'd9,
        COND_GE = 4'd10,
        COND_LT = 4'd11,
        COND_GT = 4'd12,
        COND_LE = 4'd13,
        COND_AL = 4'd14,
        COND_PF = 4'd15
    } cond_e;

    typedef struct packed {
        logic p;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HOLD  = 1'b1
    } out_state_e;

endpackage

// File: rtl/bcc_zero_detect.sv
module bcc_zero_detect #(
    parameter int DATA_W  = 32,
    parameter int CHUNK_W = 8
) (
    input  logic [DATA_W-1:0] value,
    output logic              is_zero
);
    localparam int NUM_CHUNKS = (DATA_W + CHUNK_W - 1) / CHUNK_W;
    localparam int PAD_W      = NUM_CHUNKS * CHUNK_W;

    logic [PAD_W-1:0]      padded;
    logic [NUM_CHUNKS-1:0] chunk_any;

    always_comb begin
        padded = '0;
        padded[DATA_W-1:0] = value;
    end

    // Split the OR tree into chunks to keep each level shallow.
    for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_chunk
        assign chunk_any[g] = |padded[g*CHUNK_W +: CHUNK_W];
    end

    assign is_zero = ~|chunk_any;
endmodule

// File: rtl/bcc_flag_test.sv
module bcc_flag_test
    import bcc_pkg::*;
(
    input  cond_e  cond,
    input  flags_t flags,
    input  logic   fast_path,
    input  logic   result_zero,
    output logic   taken
);
    logic z_eff;
    logic n_ne_v;

    // Fast path: zero-ness of the stored result stands in for Z.
    assign z_eff  = fast_path ? result_zero : flags.z;
    assign n_ne_v = flags.n ^ flags.v;

    always_comb begin
        unique case (cond)
            COND_CC: taken = ~flags.c;
            COND_CS: taken = flags.c;
            COND_NE: taken = ~z_eff;
            COND_EQ: taken = z_eff;
            COND_VC: taken = ~flags.v;
            COND_VS: taken = flags.v;
            COND_PL: taken = ~flags.n;
            COND_MI: taken = flags.n;
            COND_LS: taken = flags.c | flags.z;
            COND_HI: taken = ~(flags.c | flags.z);
            COND_GE: taken = ~n_ne_v;
            COND_LT: taken = n_ne_v;
            COND_GT: taken = ~flags.z & ~n_ne_v;
            COND_LE: taken = flags.z | n_ne_v;
            COND_AL: taken = 1'b1;
            COND_PF: taken = flags.p;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/bcc_out_stage.sv
module bcc_out_stage
    import bcc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              taken_d,
    output logic              valid_q,
    output logic              taken_q,
    output logic [DATA_W-1:0] set_value
);
    out_state_e state_q;
    out_state_e state_d;

    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = load ? ST_HOLD : ST_EMPTY;
            ST_HOLD:  state_d = load ? ST_HOLD : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taken_q <= 1'b0;
        end else if (load) begin
            taken_q <= taken_d;
        end
    end

    assign valid_q   = (state_q == ST_HOLD);
    assign set_value = {{(DATA_W-1){1'b0}}, taken_q};
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
    import bcc_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CHUNK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        in_cond,
    input  logic [4:0]        in_flags,
    input  logic              in_flags_live,
    input  logic              in_last_arith,
    input  logic [DATA_W-1:0] in_result,
    output logic              out_valid,
    output logic              out_taken,
    output logic [DATA_W-1:0] out_set_value
);
    logic result_zero;
    logic fast_path;
    logic taken_comb;

    assign fast_path = ~in_flags_live & in_last_arith;

    bcc_zero_detect #(
        .DATA_W  (DATA_W),
        .CHUNK_W (CHUNK_W)
    ) u_zero (
        .value   (in_result),
        .is_zero (result_zero)
    );

    bcc_flag_test u_test (
        .cond        (cond_e'(in_cond)),
        .flags       (flags_t'(in_flags)),
        .fast_path   (fast_path),
        .result_zero (result_zero),
        .taken       (taken_comb)
    );

    bcc_out_stage #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (in_valid),
        .taken_d   (taken_comb),
        .valid_q   (out_valid),
        .taken_q   (out_taken),
        .set_value (out_set_value)
    );
endmodule

// File: rtl/bcc_checker.sv
module bcc_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        in_cond,
    input logic [4:0]        in_flags,
    input logic              in_flags_live,
    input logic              in_last_arith,
    input logic [DATA_W-1:0] in_result,
    input logic              out_valid,
    input logic              out_taken,
    input logic [DATA_W-1:0] out_set_value
);
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r10_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r9_set_value_01: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_set_value == {{(DATA_W-1){1'b0}}, out_taken}));
    a_r6_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cond == 4'd14) |=> out_taken);
    a_r7_fast_eq: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cond == 4'd3 && !in_flags_live && in_last_arith)
        |=> (out_taken == ($past(in_result) == '0)));
    a_r1_slow_eq: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cond == 4'd3 && in_flags_live)
        |=> (out_taken == $past(in_flags[2])));
    a_r4_lt: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cond == 4'd11)
        |=> (out_taken == ($past(in_flags[3]) != $past(in_flags[1]))));
    a_r3_ls: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cond == 4'd8)
        |=> (out_taken == ($past(in_flags[0]) || $past(in_flags[2]))));
endmodule

bind branch_cond_eval bcc_checker #(.DATA_W(DATA_W)) u_bcc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_cond       (in_cond),
    .in_flags      (in_flags),
    .in_flags_live (in_flags_live),
    .in_last_arith (in_last_arith),
    .in_result     (in_result),
    .out_valid     (out_valid),
    .out_taken     (out_taken),
    .out_set_value (out_set_value)
);

// File: tb/test_branch_cond_eval.sv
module test_branch_cond_eval;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [3:0]        in_cond = '0;
    logic [4:0]        in_flags = '0;
    logic              in_flags_live = 1'b0;
    logic              in_last_arith = 1'b0;
    logic [DATA_W-1:0] in_result = '0;
    logic              out_valid;
    logic              out_taken;
    logic [DATA_W-1:0] out_set_value;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    branch_cond_eval #(.DATA_W(DATA_W)) i_branch_cond_eval (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_cond       (in_cond),
        .in_flags      (in_flags),
        .in_flags_live (in_flags_live),
        .in_last_arith (in_last_arith),
        .in_result     (in_result),
        .out_valid     (out_valid),
        .out_taken     (out_taken),
        .out_set_value (out_set_value)
    );

    function automatic string req_of(input int cond, input bit fast);
        if (cond == 2 || cond == 3) return fast ? "R7" : "R8";
        if (cond <= 5)  return "R1";
        if (cond <= 7)  return "R2";
        if (cond <= 9)  return "R3";
        if (cond <= 11) return "R4";
        if (cond <= 13) return "R5";
        return "R6";
    endfunction

    // Expected outcome from the requirement text; flags {P,N,Z,V,C}.
    function automatic bit expect_taken(input int cond, input logic [4:0] f,
                                        input bit fast, input logic [DATA_W-1:0] res);
        bit c = f[0], v = f[1], z = f[2], n = f[3], p = f[4];
        bit zz = fast ? (res == 0) : z;
        case (cond)
            0:  return c == 0;
            1:  return c == 1;
            2:  return zz == 0;
            3:  return zz == 1;
            4:  return v == 0;
            5:  return v == 1;
            6:  return n == 0;
            7:  return n == 1;
            8:  return (c + z) != 0;
            9:  return (c + z) == 0;
            10: return n == v;
            11: return n != v;
            12: return (z == 0) && (n == v);
            13: return (z == 1) || (n != v);
            14: return 1;
            default: return p == 1;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        logic [DATA_W-1:0] results [4];
        results[0] = '0;
        results[1] = 32'h0000_0001;
        results[2] = 32'h8000_0000;
        results[3] = 32'h0001_0000;

        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R10", out_valid, 0);   // reset state
        check(out_taken == 1'b0, "R10", out_taken, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R10", out_valid, 0);

        for (int mode = 0; mode < 4; mode++) begin
            for (int ri = 0; ri < 4; ri++) begin
                for (int cond = 0; cond < 16; cond++) begin
                    for (int fl = 0; fl < 32; fl++) begin
                        bit live  = mode[0];
                        bit arith = mode[1];
                        bit fast  = !live && arith;
                        bit exp;
                        in_valid      = 1'b1;
                        in_cond       = 4'(cond);
                        in_flags      = 5'(fl);
                        in_flags_live = live;
                        in_last_arith = arith;
                        in_result     = results[ri];
                        exp = expect_taken(cond, 5'(fl), fast, results[ri]);
                        @(negedge clk);
                        check(out_valid == 1'b1, "R10", out_valid, 1);
                        check(out_taken == exp, req_of(cond, fast), out_taken, exp);
                        check(out_set_value == DATA_W'(exp), "R9", out_set_value, DATA_W'(exp));
                    end
                end
            end
            // Idle cycle: out_valid must drop (R10).
            in_valid = 1'b0;
            @(negedge clk);
            check(out_valid == 1'b0, "R10", out_valid, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule